// File: doc/BRIEF.md
# Stop-to-Reset Restart Controller

This block sits between a processor's halt indication and its reset input. When the processor halts after detecting an error, the block can turn that halt into a short automatic reset pulse. It does so only if software armed it beforehand, and every reset disarms it again. A halt that arrives while the block is not armed leaves the processor halted, and the `halted` output reports this.

The block keeps a power-up flag so that software can tell whether the last reset came from power-on or from an automatic restart. Sticky diagnostic flags record which error detectors were active at the moment the halt began. These flags stay set through automatic restarts and are cleared one bit at a time by software writes. All of this state can be read through one status word.

Top module: `restart_ctl`

## Requirements
- R1: While `porRstN` is low, `cpuReset` is high and the status word reads armed=0, power-up=1, halted=0, diagnostics=0. `cpuReset` goes low at the first clock edge after `porRstN` rises.
- R2: A one-cycle `armWr` pulse while `cpuReset` is low sets the armed flag (status bit 0) at the next clock edge.
- R3: A rising edge on `cpuStopped` while the block is armed drives `cpuReset` high from the next clock edge for exactly RST_CYCLES (default 4) cycles.
- R4: The armed flag clears at the edge where an automatic reset starts and stays clear while `cpuReset` is high. `armWr` has no effect while `cpuReset` is high.
- R5: A rising edge on `cpuStopped` while the block is not armed causes no reset and sets `halted`. `halted` stays high until `cpuStopped` is seen low. Arming later does not produce a reset for that halt.
- R6: Each assertion of `cpuStopped` produces at most one automatic reset. If `cpuStopped` stays high after the pulse, no further pulse follows, even after re-arming.
- R7: The power-up flag (status bit 1) is set only by power-on reset. A `pwrAckWr` pulse clears it, and an automatic restart does not change it.
- R8: The diagnostic flags (status bits 3 and up; bit 3+i belongs to source i) take the OR of `errSrc` only at the edge that sees `cpuStopped` rise. `errSrc` at any other time is ignored.
- R9: The diagnostic flags persist across automatic resets. A 1 in bit i of `diagClrWr` clears flag i. When a capture and a clear hit the same flag in the same cycle, the capture wins.
- R10: The status word is {diagnostics[NSRC-1:0], halted, power-up, armed}, with armed in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| cpuStopped | input | 1 | Processor halt indication, synchronous to clk |
| armWr | input | 1 | Software strobe that arms the restart |
| pwrAckWr | input | 1 | Software strobe that clears the power-up flag |
| diagClrWr | input | NSRC | Write-one-to-clear mask for the diagnostic flags |
| errSrc | input | NSRC | Per-detector error flags |
| cpuReset | output | 1 | Reset to the processor, active high |
| statusWord | output | NSRC+3 | {diagnostics, halted, power-up, armed} |
| halted | output | 1 | Processor is halted with no restart pending |

## Verification
The assertions assume that `cpuStopped`, `errSrc` and the write strobes are synchronous to `clk`. They also assume that `porRstN` changes only away from the active edge. The stimulus drives every input on the falling edge and holds it for whole cycles, which satisfies both assumptions. The pulse-length check counts only pulses that started after power-on. It assumes the processor does not raise `cpuStopped` again while a pulse is already running. The bench keeps within this by dropping or holding `cpuStopped` steady during each pulse.

// File: rtl/restart_pkg.sv
package restart_pkg;

  // Fixed fields below the diagnostic flags in the status word.
  localparam int ARM_BIT    = 0;
  localparam int PWR_BIT    = 1;
  localparam int HALT_BIT   = 2;
  localparam int FIXED_BITS = 3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic startPulse;  // automatic reset begins at this edge
    logic capDiag;     // halt rose: capture the error sources
    logic inReset;     // reset output currently high
  } ctlStrobe_t;

endpackage

// File: rtl/restart_ctrl.sv
module restart_ctrl
  import restart_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       cpuStopped,
  input  logic       armedIn,
  output ctlStrobe_t strb,
  output logic       cpuReset,
  output logic       halted
);

  localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(RST_CYCLES - 1);

  logic          stopPrev;
  logic          resetQ;
  logic [CW-1:0] cnt;
  logic          haltQ;
  logic          stopRise;

  assign stopRise = cpuStopped & ~stopPrev;

  always_comb begin
    strb.startPulse = stopRise & armedIn;
    strb.capDiag    = stopRise;
    strb.inReset    = resetQ;
  end

  // Reset pulse generator: high during power-on, then once per armed halt.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      stopPrev <= 1'b0;
      resetQ   <= 1'b1;
      cnt      <= '0;
    end else begin
      stopPrev <= cpuStopped;
      if (stopRise && armedIn) begin
        resetQ <= 1'b1;
        cnt    <= LOAD_VAL;
      end else if (resetQ) begin
        if (cnt == '0) resetQ <= 1'b0;
        else           cnt    <= cnt - 1'b1;
      end
    end
  end

  // Halt flag: halt seen without an armed restart.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                 haltQ <= 1'b0;
    else if (stopRise && !armedIn) haltQ <= 1'b1;
    else if (!cpuStopped)          haltQ <= 1'b0;
  end

  assign cpuReset = resetQ;
  assign halted   = haltQ;

endmodule

// File: rtl/restart_datapath.sv
module restart_datapath
  import restart_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic                       clk,
  input  logic                       porRstN,
  input  ctlStrobe_t                 strb,
  input  logic                       armWr,
  input  logic                       pwrAckWr,
  input  logic [NSRC-1:0]            diagClrWr,
  input  logic [NSRC-1:0]            errSrc,
  input  logic                       haltIn,
  output logic                       armedOut,
  output logic [NSRC+FIXED_BITS-1:0] status
);

  logic            armedQ;
  logic            pwrQ;
  logic [NSRC-1:0] diagQ;

  // Arm latch: software sets it, any reset clears it.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                            armedQ <= 1'b0;
    else if (strb.inReset || strb.startPulse) armedQ <= 1'b0;
    else if (armWr)                           armedQ <= 1'b1;
  end

  // Power-up latch: only power-on sets it.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)      pwrQ <= 1'b1;
    else if (pwrAckWr) pwrQ <= 1'b0;
  end

  // One sticky latch per error source; capture beats clear.
  for (genvar i = 0; i < NSRC; i++) begin : g_diag
    logic bitQ;
    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN)                      bitQ <= 1'b0;
      else if (strb.capDiag && errSrc[i]) bitQ <= 1'b1;
      else if (diagClrWr[i])             bitQ <= 1'b0;
    end
    assign diagQ[i] = bitQ;
  end

  always_comb begin
    status           = '0;
    status[ARM_BIT]  = armedQ;
    status[PWR_BIT]  = pwrQ;
    status[HALT_BIT] = haltIn;
    status[NSRC+FIXED_BITS-1:FIXED_BITS] = diagQ;
  end

  assign armedOut = armedQ;

endmodule

// File: rtl/restart_ctl.sv
module restart_ctl
  import restart_pkg::*;
#(
  parameter int NSRC       = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic                       clk,
  input  logic                       porRstN,
  input  logic                       cpuStopped,
  input  logic                       armWr,
  input  logic                       pwrAckWr,
  input  logic [NSRC-1:0]            diagClrWr,
  input  logic [NSRC-1:0]            errSrc,
  output logic                       cpuReset,
  output logic [NSRC+FIXED_BITS-1:0] statusWord,
  output logic                       halted
);

  localparam int STAT_W = NSRC + FIXED_BITS;

  ctlStrobe_t       strb;
  logic             armed;
  logic             haltInt;
  logic [STAT_W-1:0] statusInt;

  restart_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk        (clk),
    .porRstN    (porRstN),
    .cpuStopped (cpuStopped),
    .armedIn    (armed),
    .strb       (strb),
    .cpuReset   (cpuReset),
    .halted     (haltInt)
  );

  restart_datapath #(.NSRC(NSRC)) u_dp (
    .clk       (clk),
    .porRstN   (porRstN),
    .strb      (strb),
    .armWr     (armWr),
    .pwrAckWr  (pwrAckWr),
    .diagClrWr (diagClrWr),
    .errSrc    (errSrc),
    .haltIn    (haltInt),
    .armedOut  (armed),
    .status    (statusInt)
  );

  assign halted     = haltInt;
  assign statusWord = statusInt;

endmodule

// File: rtl/restart_ctl_chk.sv
module restart_ctl_chk #(
  parameter int NSRC       = 4,
  parameter int RST_CYCLES = 4
) (
  input logic            clk,
  input logic            porRstN,
  input logic            cpuStopped,
  input logic [NSRC-1:0] diagClrWr,
  input logic            cpuReset,
  input logic            armedBit,
  input logic            pwrBit,
  input logic [NSRC-1:0] diagBits,
  input logic            halted
);

  int   runLen;
  logic rstPrev;
  logic autoRun;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      runLen  <= 0;
      rstPrev <= 1'b1;
      autoRun <= 1'b0;
    end else begin
      runLen  <= cpuReset ? runLen + 1 : 0;
      rstPrev <= cpuReset;
      autoRun <= cpuReset & (autoRun | ~rstPrev);
    end
  end

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!porRstN)
    ($fell(cpuReset) && autoRun) |-> (runLen == RST_CYCLES));

  // R3
  armed_start_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(cpuReset) |-> ($past(armedBit) && $past(cpuStopped)));

  // R4
  disarm_in_reset_chk: assert property (@(posedge clk) disable iff (!porRstN)
    cpuReset |-> !armedBit);

  // R5
  halt_unarmed_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(halted) |-> !$past(armedBit));

  // R7
  pwr_no_set_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !$rose(pwrBit));

  // R9
  diag_sticky_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (($past(diagBits) & ~$past(diagClrWr) & ~diagBits) == '0));

endmodule

bind restart_ctl restart_ctl_chk #(.NSRC(NSRC), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk        (clk),
  .porRstN    (porRstN),
  .cpuStopped (cpuStopped),
  .diagClrWr  (diagClrWr),
  .cpuReset   (cpuReset),
  .armedBit   (statusWord[0]),
  .pwrBit     (statusWord[1]),
  .diagBits   (statusWord[STAT_W-1:3]),
  .halted     (halted)
);

// File: tb/sim_restart_ctl.sv
module sim_restart_ctl;

  localparam int PERIOD = 10;
  localparam int NSRC   = 4;
  localparam int SW     = NSRC + 3;

  logic            clk = 1'b0;
  logic            porRstN;
  logic            cpuStopped;
  logic            armWr;
  logic            pwrAckWr;
  logic [NSRC-1:0] diagClrWr;
  logic [NSRC-1:0] errSrc;
  logic            cpuReset;
  logic [SW-1:0]   statusWord;
  logic            halted;

  restart_ctl #(.NSRC(NSRC), .RST_CYCLES(4)) u0 (
    .clk(clk), .porRstN(porRstN), .cpuStopped(cpuStopped), .armWr(armWr),
    .pwrAckWr(pwrAckWr), .diagClrWr(diagClrWr), .errSrc(errSrc),
    .cpuReset(cpuReset), .statusWord(statusWord), .halted(halted)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    int          cyc;
    logic        rst;
    logic        hlt;
    logic [SW-1:0] st;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    finished = 0;

  // Driver helper: expectation for the outputs after the coming edge.
  task automatic tick(input string tag, input logic r, input logic h,
                      input logic [SW-1:0] s);
    item_t it;
    it.cyc = cyc + 1; it.rst = r; it.hlt = h; it.st = s; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compare a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #(PERIOD/4);
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        item_t it;
        it = q.pop_front();
        nChecks++;
        if (cpuReset !== it.rst || halted !== it.hlt || statusWord !== it.st) begin
          nFails++;
          $display("FAIL %s cyc %0d: actual rst=%b halt=%b st=%b expected rst=%b halt=%b st=%b",
                   it.tag, cyc, cpuReset, halted, statusWord, it.rst, it.hlt, it.st);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(PERIOD * 5000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    porRstN = 1'b0; cpuStopped = 1'b0; armWr = 1'b0; pwrAckWr = 1'b0;
    diagClrWr = '0; errSrc = '0;
    // R1 / R10: reset state, status = {diag,halt,pwr,armed}
    tick("R1", 1'b1, 1'b0, 7'b0000010);
    tick("R1", 1'b1, 1'b0, 7'b0000010);
    porRstN = 1'b1;
    tick("R1", 1'b0, 1'b0, 7'b0000010);
    // R2: arm
    armWr = 1'b1;
    tick("R2", 1'b0, 1'b0, 7'b0000011);
    armWr = 1'b0;
    tick("R2", 1'b0, 1'b0, 7'b0000011);
    // R3 / R8: armed halt with sources 0101
    errSrc = 4'b0101; cpuStopped = 1'b1;
    tick("R3", 1'b1, 1'b0, 7'b0101010);
    // R4: arm attempt during pulse ignored; R8: later errSrc ignored
    cpuStopped = 1'b0; armWr = 1'b1; errSrc = 4'b1010;
    tick("R4", 1'b1, 1'b0, 7'b0101010);
    armWr = 1'b0;
    tick("R3", 1'b1, 1'b0, 7'b0101010);
    tick("R3", 1'b1, 1'b0, 7'b0101010);
    tick("R3", 1'b0, 1'b0, 7'b0101010);
    errSrc = '0;
    tick("R4", 1'b0, 1'b0, 7'b0101010);
    // R7: clear power-up flag
    pwrAckWr = 1'b1;
    tick("R7", 1'b0, 1'b0, 7'b0101000);
    pwrAckWr = 1'b0;
    // R5: unarmed halt, source 0010
    errSrc = 4'b0010; cpuStopped = 1'b1;
    tick("R5", 1'b0, 1'b1, 7'b0111100);
    errSrc = '0;
    tick("R5", 1'b0, 1'b1, 7'b0111100);
    armWr = 1'b1;
    tick("R5", 1'b0, 1'b1, 7'b0111101);
    armWr = 1'b0;
    tick("R5", 1'b0, 1'b1, 7'b0111101);
    cpuStopped = 1'b0;
    tick("R5", 1'b0, 1'b0, 7'b0111001);
    // R6: armed halt held high through and after the pulse
    cpuStopped = 1'b1; errSrc = 4'b1000;
    tick("R6", 1'b1, 1'b0, 7'b1111000);
    errSrc = '0;
    tick("R6", 1'b1, 1'b0, 7'b1111000);
    tick("R6", 1'b1, 1'b0, 7'b1111000);
    tick("R6", 1'b1, 1'b0, 7'b1111000);
    tick("R6", 1'b0, 1'b0, 7'b1111000);
    tick("R7", 1'b0, 1'b0, 7'b1111000);
    armWr = 1'b1;
    tick("R6", 1'b0, 1'b0, 7'b1111001);
    armWr = 1'b0;
    tick("R6", 1'b0, 1'b0, 7'b1111001);
    tick("R6", 1'b0, 1'b0, 7'b1111001);
    cpuStopped = 1'b0;
    tick("R6", 1'b0, 1'b0, 7'b1111001);
    // R9: clear flags 0 and 1; R8: errSrc without halt ignored
    diagClrWr = 4'b0011; errSrc = 4'b0011;
    tick("R9", 1'b0, 1'b0, 7'b1100001);
    diagClrWr = '0; errSrc = '0;
    tick("R8", 1'b0, 1'b0, 7'b1100001);
    // R9: capture beats clear on flag 0
    cpuStopped = 1'b1; errSrc = 4'b0001; diagClrWr = 4'b0001;
    tick("R9", 1'b1, 1'b0, 7'b1101000);
    cpuStopped = 1'b0; errSrc = '0; diagClrWr = '0;
    tick("R9", 1'b1, 1'b0, 7'b1101000);
    tick("R9", 1'b1, 1'b0, 7'b1101000);
    tick("R9", 1'b1, 1'b0, 7'b1101000);
    tick("R9", 1'b0, 1'b0, 7'b1101000);
    // R1 / R7: power-on again restores the power-up flag
    porRstN = 1'b0;
    tick("R1", 1'b1, 1'b0, 7'b0000010);
    porRstN = 1'b1;
    tick("R7", 1'b0, 1'b0, 7'b0000010);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule